// File: doc/BRIEF.md
# Flash Block Protection Checker

This block judges every flash operation against two protection policies that are kept per 2 KB flash block. Each 2 KB block is two 1 KB erase blocks taken together. The first policy is the program-enable policy, and it decides whether a block may be changed. The second is the read-enable policy, and it decides whether a block may be read as data, either by software or by a debugger. Instruction fetch is never refused. A block with both bits cleared can therefore still run code, but it cannot be read, programmed or erased. This is the execute-only mode. A block with only its program-enable bit cleared is read-only.

Each cycle the block accepts at most one request, made of an operation code and a flash byte address. One cycle later it answers with an allow or deny decision. A denied request also raises a one-cycle violation pulse, which the flash sequencer uses to abandon the operation. Both policies are held in this block as four 32-bit words each. A word write can only clear policy bits, so protection can be tightened but never loosened until the next reset.

Top module: `flash_guard`

## Requirements
- R1: The block number is byte address bits [17:11], and the low 11 bits have no effect. Block b uses policy bit b, which is bit b%32 of word b/32 of each policy output vector.
- R2: During reset and after it, every bit of both policy vectors is 1, and resp_valid and viol_pulse are 0.
- R3: An instruction fetch (req_op 0) is always allowed, whatever the block's policy bits.
- R4: A data read (req_op 1) and a debug read (req_op 2) are allowed only when the block's read-enable bit is 1.
- R5: A program (req_op 3) and an erase (req_op 4) are allowed only when the block's program-enable bit is 1. This refuses both operations on read-only and execute-only blocks.
- R6: A policy write with cfg_we=1 selects one policy (cfg_pol 0 = program-enable, 1 = read-enable) and one word (cfg_word). That word becomes its old value ANDed with cfg_data. No policy bit ever goes from 0 to 1, and all other words are unchanged.
- R7: Each request with req_valid=1 gets resp_valid=1 exactly one cycle later. viol_pulse is 1 in exactly the response cycles of denied requests. Op codes 5 to 7 are always denied.
- R8: A request made in the same cycle as a policy write is judged against the policy value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Operation request present this cycle |
| req_op | input | 3 | Operation: 0 fetch, 1 data read, 2 debug read, 3 program, 4 erase |
| req_addr | input | 18 | Flash byte address |
| cfg_we | input | 1 | Policy word write strobe |
| cfg_pol | input | 1 | Policy select: 0 program-enable, 1 read-enable |
| cfg_word | input | 2 | Index of the 32-bit word within the policy |
| cfg_data | input | 32 | Mask ANDed into the selected word |
| resp_valid | output | 1 | Decision present (one cycle after request) |
| resp_allow | output | 1 | 1 = operation allowed |
| viol_pulse | output | 1 | One-cycle pulse for a refused operation |
| prog_en_o | output | 128 | Program-enable policy, one bit per block |
| read_en_o | output | 128 | Read-enable policy, one bit per block |

## Verification
Several rules are checked by the bound assertions on every cycle. They check that a fetch is never denied, and that a read or a change is decided by the right policy bit of the block addressed one cycle earlier. They also check that no policy bit ever rises, that every request gets a response on the next cycle, and that the violation pulse matches the denials. Other behaviours show up only in the bench's scenarios. These are the reset values, the mapping of block numbers to word and bit positions, and the fact that the offset within a block has no effect. The scenarios also cover the ordering of a write against a request in the same cycle, and the full sequence through full-access, read-only, execute-only and write-only blocks.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;
  localparam logic [2:0] OP_FETCH = 3'd0;
  localparam logic [2:0] OP_DREAD = 3'd1;
  localparam logic [2:0] OP_DBGRD = 3'd2;
  localparam logic [2:0] OP_PROG  = 3'd3;
  localparam logic [2:0] OP_ERASE = 3'd4;

  localparam int NUM_POL  = 2;
  localparam int POL_PROG = 0;
  localparam int POL_READ = 1;
endpackage

// File: rtl/flash_guard_bank.sv
module flash_guard_bank #(
  parameter int NUM_BLK = 128,
  parameter int WORD_W  = 32,
  localparam int NUM_WORDS = NUM_BLK / WORD_W,
  localparam int SEL_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [SEL_W-1:0]   wr_idx,
  input  logic [WORD_W-1:0]  wr_mask,
  output logic [NUM_BLK-1:0] bits_o
);
  logic [NUM_WORDS-1:0][WORD_W-1:0] pol_q;
  logic [NUM_WORDS-1:0][WORD_W-1:0] pol_d;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    always_comb begin
      pol_d[w] = pol_q[w];
      if (wr_en && (wr_idx == SEL_W'(w))) begin
        pol_d[w] = pol_q[w] & wr_mask;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q <= '1;
    end else if (wr_en) begin
      pol_q <= pol_d;
    end
  end

  assign bits_o = pol_q;
endmodule

// File: rtl/flash_guard_decide.sv
module flash_guard_decide
  import flash_guard_pkg::*;
(
  input  logic [2:0] op,
  input  logic       prog_ok,
  input  logic       read_ok,
  output logic       allow
);
  always_comb begin
    unique case (op)
      OP_FETCH:           allow = 1'b1;
      OP_DREAD, OP_DBGRD: allow = read_ok;
      OP_PROG, OP_ERASE:  allow = prog_ok;
      default:            allow = 1'b0;
    endcase
  end
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flash_guard_pkg::*;
#(
  parameter int NUM_BLK  = 128,
  parameter int BLK_LOG2 = 11,
  parameter int WORD_W   = 32,
  localparam int IDX_W     = $clog2(NUM_BLK),
  localparam int ADDR_W    = IDX_W + BLK_LOG2,
  localparam int NUM_WORDS = NUM_BLK / WORD_W,
  localparam int SEL_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [2:0]         req_op,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic               cfg_we,
  input  logic               cfg_pol,
  input  logic [SEL_W-1:0]   cfg_word,
  input  logic [WORD_W-1:0]  cfg_data,
  output logic               resp_valid,
  output logic               resp_allow,
  output logic               viol_pulse,
  output logic [NUM_BLK-1:0] prog_en_o,
  output logic [NUM_BLK-1:0] read_en_o
);
  logic [NUM_POL-1:0][NUM_BLK-1:0] pol_bits;

  for (genvar p = 0; p < NUM_POL; p++) begin : g_pol
    flash_guard_bank #(
      .NUM_BLK (NUM_BLK),
      .WORD_W  (WORD_W)
    ) bank_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we && (cfg_pol == 1'(p))),
      .wr_idx  (cfg_word),
      .wr_mask (cfg_data),
      .bits_o  (pol_bits[p])
    );
  end

  assign prog_en_o = pol_bits[POL_PROG];
  assign read_en_o = pol_bits[POL_READ];

  // block number decode; the in-block offset is deliberately dropped
  logic [IDX_W-1:0] blk_idx;
  logic             unused_offset;
  assign blk_idx       = req_addr[ADDR_W-1:BLK_LOG2];
  assign unused_offset = ^req_addr[BLK_LOG2-1:0];

  logic allow_c;
  flash_guard_decide decide_i (
    .op      (req_op),
    .prog_ok (prog_en_o[blk_idx]),
    .read_ok (read_en_o[blk_idx]),
    .allow   (allow_c)
  );

  // response next-state
  logic valid_d, allow_d, viol_d;
  always_comb begin
    valid_d = req_valid;
    allow_d = allow_c;
    viol_d  = req_valid && !allow_c;
  end

  // response registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      viol_pulse <= 1'b0;
    end else begin
      resp_valid <= valid_d;
      viol_pulse <= viol_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_allow <= 1'b0;
    end else if (req_valid) begin
      resp_allow <= allow_d;
    end
  end
endmodule

// File: rtl/flash_guard_chk.sv
module flash_guard_chk #(
  parameter int NUM_BLK = 128,
  localparam int IDX_W  = $clog2(NUM_BLK)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [2:0]         req_op,
  input logic [IDX_W-1:0]   req_blk,
  input logic               resp_valid,
  input logic               resp_allow,
  input logic               viol_pulse,
  input logic [NUM_BLK-1:0] prog_en_o,
  input logic [NUM_BLK-1:0] read_en_o
);
  // R3
  fetch_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (req_op == 3'd0) |=> resp_allow);

  // R4
  read_policy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && ((req_op == 3'd1) || (req_op == 3'd2))
    |=> (resp_allow == $past(read_en_o[req_blk])));

  // R5
  change_policy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && ((req_op == 3'd3) || (req_op == 3'd4))
    |=> (resp_allow == $past(prog_en_o[req_blk])));

  // R6
  prog_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((prog_en_o & ~$past(prog_en_o)) == '0));

  // R6
  read_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((read_en_o & ~$past(read_en_o)) == '0));

  // R7
  resp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);

  // R7
  viol_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_pulse == (resp_valid && !resp_allow));
endmodule

bind flash_guard flash_guard_chk #(.NUM_BLK(NUM_BLK)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_op     (req_op),
  .req_blk    (req_addr[ADDR_W-1:BLK_LOG2]),
  .resp_valid (resp_valid),
  .resp_allow (resp_allow),
  .viol_pulse (viol_pulse),
  .prog_en_o  (prog_en_o),
  .read_en_o  (read_en_o)
);

// File: tb/flash_guard_tb_top.sv
`timescale 1ns/1ps
module flash_guard_tb_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid;
  logic [2:0]   req_op;
  logic [17:0]  req_addr;
  logic         cfg_we;
  logic         cfg_pol;
  logic [1:0]   cfg_word;
  logic [31:0]  cfg_data;
  logic         resp_valid, resp_allow, viol_pulse;
  logic [127:0] prog_en_o, read_en_o;

  always #2 clk = ~clk;

  flash_guard dut_i (.*);

  int nchk = 0;
  int nfail = 0;
  logic [127:0] m_prog, m_read;
  bit     q_allow[$];
  string  q_tag[$];
  bit     mon_on = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every response
  always @(negedge clk) begin
    if (mon_on) begin
      if (resp_valid) begin
        if (q_allow.size() == 0) begin
          check(1'b0, "R7", "unexpected response", 128'(resp_allow), 128'd0);
        end else begin
          bit    ea;
          string et;
          ea = q_allow.pop_front();
          et = q_tag.pop_front();
          check(resp_allow == ea, et, "allow", 128'(resp_allow), 128'(ea));
          check(viol_pulse == !ea, "R7", "viol_pulse", 128'(viol_pulse), 128'(!ea));
        end
      end else begin
        check(!viol_pulse, "R7", "pulse without response", 128'(viol_pulse), 128'd0);
      end
    end
  end

  function automatic bit expect_allow(input logic [2:0] op, input int blk);
    case (op)
      3'd0:       return 1'b1;
      3'd1, 3'd2: return m_read[blk];
      3'd3, 3'd4: return m_prog[blk];
      default:    return 1'b0;
    endcase
  endfunction

  // driver: one cycle of stimulus, called at a falling edge
  task automatic step(input bit rv, input logic [2:0] op, input int blk, input int off,
                      input bit we, input bit pol, input int word, input logic [31:0] data,
                      input string tag);
    if (rv) begin
      q_allow.push_back(expect_allow(op, blk));
      q_tag.push_back(tag);
    end
    if (we) begin
      for (int b = 0; b < 32; b++) begin
        if (pol) m_read[word*32+b] = m_read[word*32+b] & data[b];
        else     m_prog[word*32+b] = m_prog[word*32+b] & data[b];
      end
    end
    req_valid = rv;
    req_op    = op;
    req_addr  = 18'((blk << 11) | (off & 11'h7ff));
    cfg_we    = we;
    cfg_pol   = pol;
    cfg_word  = 2'(word);
    cfg_data  = data;
    @(negedge clk);
    req_valid = 1'b0;
    cfg_we    = 1'b0;
  endtask

  task automatic req(input logic [2:0] op, input int blk, input int off, input string tag);
    step(1'b1, op, blk, off, 1'b0, 1'b0, 0, 32'h0, tag);
  endtask

  task automatic wr(input bit pol, input int word, input logic [31:0] data);
    step(1'b0, 3'd0, 0, 0, 1'b1, pol, word, data, "");
  endtask

  task automatic idle();
    step(1'b0, 3'd0, 0, 0, 1'b0, 1'b0, 0, 32'h0, "");
  endtask

  task automatic chk_pol(input string tag);
    check(prog_en_o == m_prog, tag, "prog_en_o", prog_en_o, m_prog);
    check(read_en_o == m_read, tag, "read_en_o", read_en_o, m_read);
  endtask

  bit done = 1'b0;
  initial begin
    #(4 * 100000);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    m_prog = '1; m_read = '1;
    rst_n = 1'b0; req_valid = 1'b0; req_op = 3'd0; req_addr = '0;
    cfg_we = 1'b0; cfg_pol = 1'b0; cfg_word = '0; cfg_data = '0;
    repeat (3) @(negedge clk);
    // R2 reset state
    check(resp_valid == 1'b0 && viol_pulse == 1'b0, "R2", "outputs in reset",
          {resp_valid, viol_pulse}, 128'd0);
    chk_pol("R2");
    rst_n = 1'b1;
    mon_on = 1'b1;
    idle();
    chk_pol("R2");

    // full access block 5: everything allowed (R3 R4 R5)
    req(3'd0, 5, 0,     "R3");
    req(3'd1, 5, 16,    "R4");
    req(3'd2, 5, 32,    "R4");
    req(3'd3, 5, 64,    "R5");
    req(3'd4, 5, 0,     "R5");

    // block 5 read-only: bit 5 of program word 0 (R1 R6)
    wr(1'b0, 0, ~(32'h1 << 5));
    chk_pol("R6");
    req(3'd0, 5, 0,     "R3");
    req(3'd1, 5, 12'h400, "R1");  // upper 1KB half, same policy
    req(3'd3, 5, 12'h7fc, "R5");
    req(3'd4, 5, 0,     "R5");
    req(3'd3, 4, 12'h7ff, "R1");  // neighbour unaffected
    req(3'd3, 6, 0,     "R1");

    // block 5 execute-only (R3 R4 R5)
    wr(1'b1, 0, ~(32'h1 << 5));
    chk_pol("R6");
    req(3'd0, 5, 0,     "R3");
    req(3'd1, 5, 0,     "R4");
    req(3'd2, 5, 12'h3ff, "R4");
    req(3'd4, 5, 0,     "R5");

    // block 100 = word 3 bit 4, read-enable cleared only (R1 R4 R5)
    wr(1'b1, 3, ~(32'h1 << 4));
    chk_pol("R6");
    req(3'd2, 100, 12'h7ff, "R4");
    req(3'd3, 100, 0,   "R5");
    req(3'd0, 100, 8,   "R3");
    req(3'd1, 99,  12'h7ff, "R1");
    req(3'd1, 101, 0,   "R1");

    // attempts to set bits again have no effect (R6)
    wr(1'b0, 0, 32'hffff_ffff);
    wr(1'b1, 3, 32'hffff_ffff);
    chk_pol("R6");
    req(3'd3, 5, 0,     "R6");
    req(3'd1, 100, 0,   "R6");

    // same-cycle write and request on block 127 (R8)
    step(1'b1, 3'd3, 127, 0, 1'b1, 1'b0, 3, ~(32'h1 << 31), "R8");
    req(3'd3, 127, 0,   "R8");
    chk_pol("R6");

    // reserved op codes and back-to-back denials (R7)
    req(3'd5, 0, 0,     "R7");
    req(3'd7, 0, 0,     "R7");
    req(3'd6, 64, 0,    "R7");
    req(3'd0, 0, 0,     "R7");
    idle();
    idle();
    check(q_allow.size() == 0, "R7", "pending responses", 128'(q_allow.size()), 128'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule